// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A 16-bit up-counter advances once per prescaled tick, with the divide ratio picked as a power of two from 1 to 128. Four channels sit beside it. In capture mode a channel watches its own asynchronous input and, on the chosen edge, stores the counter value and raises its flag. In compare mode the channel raises its flag when the counter holds the channel's value at a tick. The last channel can also act as a terminal count: with modulus enabled, the counter returns to zero on a match, so the timer becomes an up-counting modulus counter.

Software reaches the block through a plain synchronous register port. Writes take effect at the clock edge. Reads are combinational from the address. Flags are write-one-to-clear. One interrupt line combines every flag whose enable bit is set.

Register map (word addresses): 0 = control, 1 = channel interrupt enables, 2 = channel modes and edge selects, 3 = flags, 4 = counter (read-only), 8+n = channel n value.

Top module: `capcmp_timer4`

## Requirements
- R1: After reset, the control, enable, mode and flag registers read 0, the counter reads 0 and `irq` is low.
- R2: The counter advances by one every 2^PR clocks, where PR is control bits [2:0]. Its natural wrap from 0xFFFF to 0x0000 sets the overflow flag, which is flag register bit 7.
- R3: A newly written PR takes effect only at a clock where every prescale stage is zero. Until then the old ratio stays in force.
- R4: With control bit 3 set, a tick that finds the counter equal to the channel 3 value loads 0x0000 instead of incrementing.
- R5: With control bit 3 set and a channel 3 value of 0x0000, the counter stays at 0x0000.
- R6: With control bit 3 set and a channel 3 value of 0xFFFF, the return from 0xFFFF to 0x0000 leaves the overflow flag clear.
- R7: In capture mode, the channel n edge select sits in mode register bits [9+2n:8+2n]. Code 00 means no capture, 01 means rising edges, 10 means falling edges and 11 means both. The input passes a two-flop synchronizer. The value stored is the counter value two clocks after the new level is first sampled, and flag n is set.
- R8: Mode register bit n set puts channel n in compare mode. A tick at which the counter equals the channel value sets flag n.
- R9: Writing the flag register clears each flag whose data bit is 1 and leaves the others unchanged.
- R10: `irq` is high when any channel flag n is set with enable bit n (enable register bits [3:0]) set, or when the overflow flag is set with control bit 7 set.
- R11: Channel value registers read back what was written. Writes to the counter address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| cap_in | input | 4 | Asynchronous capture inputs, one per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
Capture is tried with each of the four edge codes, each facing both a rising and a falling input. This separates the four codes and confirms that the stored value matches the counter two clocks after the synchronizer. Compare and the modulus mode are tried with a small terminal count, a zero terminal count and 0xFFFF. These three distinguish a normal reload, a counter pinned at zero, and a reload that must not be mistaken for an overflow, against a free-running wrap that must set it. The prescaler is measured over fixed windows at several ratios. A ratio change written just after the stages reach zero shows whether the change waits for the next all-zero point.

// File: rtl/tim_pkg.sv
// Package: register addresses and bit positions shared by the timer modules.
// Assumes a 16-bit data word so that four two-bit edge fields fit at bit 8 and up.
package tim_pkg;
    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_IE      = 1;
    localparam int ADDR_MODE    = 2;
    localparam int ADDR_FLAG    = 3;
    localparam int ADDR_CNT     = 4;
    localparam int ADDR_CH0     = 8;
    localparam int CTRL_MOD_BIT = 3;
    localparam int CTRL_OIE_BIT = 7;
    localparam int FLAG_OVF_BIT = 7;
    localparam int EDGE_BASE    = 8;
endpackage

// File: rtl/tim_prescaler.sv
// Module: power-of-two clock prescaler.
// Produces a one-cycle tick every 2^ps_act clocks. A requested ratio is
// adopted only on a clock where every prescale stage is zero.
// Assumes PS_W is small (2^PS_W - 1 stages).
module tim_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_req,
    output logic            tick
);
    localparam int STG = (1 << PS_W) - 1;

    logic [STG-1:0]  stg_cnt;
    logic [STG-1:0]  mask;
    logic [PS_W-1:0] ps_act;

    // Free-running stage counter.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_cnt <= '0;
        else        stg_cnt <= stg_cnt + 1'b1;
    end

    // Adopt the requested ratio only when all stages are zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               ps_act <= '0;
        else if (stg_cnt == '0)   ps_act <= ps_req;
    end

    // Mask of the low ps_act stages.
    always_comb begin
        for (int i = 0; i < STG; i++) mask[i] = (i < int'(ps_act));
    end

    // Tick when the masked stages are all ones.
    assign tick = ((stg_cnt & mask) == mask);

    // R3: active ratio only moves at the all-zero point.
    p_ps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_cnt != '0) |=> $stable(ps_act));
endmodule

// File: rtl/tim_counter.sv
// Module: main up-counter with optional modulus reload.
// Advances on tick. With mod_en set, a tick that finds cnt equal to top_val
// loads zero and produces no wrap pulse. Otherwise a tick at all-ones
// produces a one-cycle wrap pulse.
module tim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mod_en,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic top_hit;

    // Modulus match against the terminal channel.
    assign top_hit = mod_en && (cnt == top_val);

    // Count register: reload on modulus match, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (tick)     cnt <= top_hit ? '0 : cnt + 1'b1;
    end

    // Natural overflow pulse.
    assign wrap = tick && !top_hit && (cnt == '1);

    // R2: an ordinary tick adds exactly one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(mod_en && cnt == top_val)) |=> (cnt == $past(cnt) + 1'b1));
    // R2: no tick, no change.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R5: zero terminal count pins the counter.
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && top_val == '0 && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/tim_cap_edge.sv
// Module: capture input synchronizer and edge selector.
// Two flops bring the asynchronous pin into the clock domain and a third
// holds the previous level. sel[0] enables rising and sel[1] enables falling.
module tim_cap_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    logic s1, s2, prev;

    // Synchronizer chain and previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Qualified edge event.
    assign hit = (sel[0] && s2 && !prev) || (sel[1] && !s2 && prev);

    // R7: disabled select never reports an edge.
    p_sel_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> !hit);
endmodule

// File: rtl/capcmp_timer4.sv
// Module: four-channel capture/compare timer with register port.
// Holds control, enable, mode, flag and channel registers. Writes land at
// the clock edge and reads are combinational. The last channel serves as the
// modulus terminal count. Assumes CNT_W >= EDGE_BASE + 2*NUM_CH and PS_W <= 3.
module capcmp_timer4 #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] cap_in,
    output logic              irq
);
    import tim_pkg::*;

    localparam int TOP_CH = NUM_CH - 1;

    logic [PS_W-1:0]     ps_req;
    logic                mod_en;
    logic                ovf_ie;
    logic [NUM_CH-1:0]   ch_ie;
    logic [NUM_CH-1:0]   cmp_mode;
    logic [2*NUM_CH-1:0] edge_sel;
    logic                ovf_flag;
    logic [NUM_CH-1:0]   ch_flag;
    logic [CNT_W-1:0]    ch_val [NUM_CH];
    logic                tick;
    logic                wrap;
    logic [CNT_W-1:0]    cnt;
    logic                wr_flag;

    assign wr_flag = wr_en && (addr == ADDR_W'(ADDR_FLAG));

    tim_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .ps_req(ps_req), .tick(tick)
    );

    tim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mod_en(mod_en),
        .top_val(ch_val[TOP_CH]), .cnt(cnt), .wrap(wrap)
    );

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_req   <= '0;
            mod_en   <= 1'b0;
            ovf_ie   <= 1'b0;
            ch_ie    <= '0;
            cmp_mode <= '0;
            edge_sel <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                ps_req <= wr_data[PS_W-1:0];
                mod_en <= wr_data[CTRL_MOD_BIT];
                ovf_ie <= wr_data[CTRL_OIE_BIT];
            end
            if (addr == ADDR_W'(ADDR_IE))
                ch_ie <= wr_data[NUM_CH-1:0];
            if (addr == ADDR_W'(ADDR_MODE)) begin
                cmp_mode <= wr_data[NUM_CH-1:0];
                edge_sel <= wr_data[EDGE_BASE +: 2*NUM_CH];
            end
        end
    end

    // Overflow flag: set by a natural wrap, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf_flag <= 1'b0;
        else if (wrap)                           ovf_flag <= 1'b1;
        else if (wr_flag && wr_data[FLAG_OVF_BIT]) ovf_flag <= 1'b0;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             hit;
        logic             set_ev;
        logic [CNT_W-1:0] val_q;
        logic             flag_q;

        tim_cap_edge u_edge (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[g]),
            .sel(edge_sel[2*g +: 2]), .hit(hit)
        );

        // Flag event for the channel's selected mode.
        assign set_ev = cmp_mode[g] ? (tick && cnt == val_q) : hit;

        // Channel value: capture wins over a software write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  val_q <= '0;
            else if (!cmp_mode[g] && hit)                val_q <= cnt;
            else if (wr_en && addr == ADDR_W'(ADDR_CH0 + g)) val_q <= wr_data;
        end

        // Channel flag: set wins over write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                    flag_q <= 1'b0;
            else if (set_ev)               flag_q <= 1'b1;
            else if (wr_flag && wr_data[g]) flag_q <= 1'b0;
        end

        assign ch_val[g]  = val_q;
        assign ch_flag[g] = flag_q;

        // R7: a qualified capture edge leaves the flag set.
        p_capture_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_mode[g] && hit) |=> flag_q);
        // R8: a compare match leaves the flag set.
        p_compare_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_mode[g] && tick && cnt == val_q) |=> flag_q);
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[PS_W-1:0]    = ps_req;
            rd_data[CTRL_MOD_BIT] = mod_en;
            rd_data[CTRL_OIE_BIT] = ovf_ie;
        end else if (addr == ADDR_W'(ADDR_IE)) begin
            rd_data[NUM_CH-1:0] = ch_ie;
        end else if (addr == ADDR_W'(ADDR_MODE)) begin
            rd_data[NUM_CH-1:0]            = cmp_mode;
            rd_data[EDGE_BASE +: 2*NUM_CH] = edge_sel;
        end else if (addr == ADDR_W'(ADDR_FLAG)) begin
            rd_data[NUM_CH-1:0]   = ch_flag;
            rd_data[FLAG_OVF_BIT] = ovf_flag;
        end else if (addr == ADDR_W'(ADDR_CNT)) begin
            rd_data = cnt;
        end else begin
            for (int i = 0; i < NUM_CH; i++)
                if (addr == ADDR_W'(ADDR_CH0 + i)) rd_data = ch_val[i];
        end
    end

    // Combined interrupt request.
    assign irq = (|(ch_flag & ch_ie)) || (ovf_flag && ovf_ie);

    // R6: modulus reload at all-ones never raises overflow.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mod_en && ch_val[TOP_CH] == '1 && cnt == '1 && !ovf_flag)
        |=> !ovf_flag);
    // R10: an enabled, set channel flag always drives irq.
    p_irq_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_flag & ch_ie)) |-> irq);
endmodule

// File: tb/capcmp_timer4_bench.sv
module capcmp_timer4_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic [3:0]  cap_in = 4'd0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [3:0] A_CTRL = 4'd0, A_IE = 4'd1, A_MODE = 4'd2,
                           A_FLAG = 4'd3, A_CNT = 4'd4, A_CH0 = 4'd8;

    always #10 clk = ~clk;

    capcmp_timer4 u_capcmp_timer4 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poll_count(input logic [15:0] target);
        logic [15:0] c;
        for (int i = 0; i < 70000; i++) begin
            rd(A_CNT, c);
            if (c == target) return;
            @(negedge clk);
        end
        chk("poll", 32'(c), 32'(target));
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        rd(A_CNT, d);  chk("R1 count", 32'(d), 0);
        rd(A_CTRL, d); chk("R1 ctrl", 32'(d), 0);
        rd(A_IE, d);   chk("R1 ie", 32'(d), 0);
        rd(A_MODE, d); chk("R1 mode", 32'(d), 0);
        rd(A_FLAG, d); chk("R1 flags", 32'(d), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regs();
        logic [15:0] c, d;
        wr(A_CH0 + 4'd2, 16'hA5C3);
        rd(A_CH0 + 4'd2, d); chk("R11 ch2 readback", 32'(d), 32'hA5C3);
        rd(A_CNT, c);
        wr(A_CNT, 16'h1234);
        rd(A_CNT, d); chk("R11 count write ignored", 32'(d), 32'(c + 16'd1));
    endtask

    task automatic t_modulus();
        logic [15:0] c, prev, mx;
        bit seen;
        wr(A_CH0 + 4'd3, 16'd200);
        wr(A_CTRL, 16'h0008);
        mx = 0; seen = 0;
        rd(A_CNT, prev);
        for (int i = 0; i < 450; i++) begin
            @(negedge clk);
            rd(A_CNT, c);
            if (c > mx) mx = c;
            if (prev == 16'd200 && c == 16'd0) seen = 1;
            prev = c;
        end
        chk("R4 max count", 32'(mx), 200);
        chk("R4 reload seen", 32'(seen), 1);
    endtask

    task automatic t_hold_zero();
        logic [15:0] c;
        bit bad;
        poll_count(16'd200);
        wr(A_CH0 + 4'd3, 16'h0000);
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            rd(A_CNT, c);
            if (c != 0) bad = 1;
            @(negedge clk);
        end
        chk("R5 counter pinned at zero", 32'(bad), 0);
    endtask

    // Change cap_in[0] and check capture outcome.
    task automatic cap_event(input logic lvl, input bit expect_cap, input string req);
        logic [15:0] c, v0, v, f;
        rd(A_CH0, v0);
        rd(A_CNT, c);
        cap_in[0] = lvl;
        wait_cyc(6);
        rd(A_CH0, v);
        rd(A_FLAG, f);
        if (expect_cap) begin
            chk({req, " value"}, 32'(v), 32'(c + 16'd2));
            chk({req, " flag"}, 32'(f[0]), 1);
        end else begin
            chk({req, " value"}, 32'(v), 32'(v0));
            chk({req, " flag"}, 32'(f[0]), 0);
        end
        wr(A_FLAG, 16'h0001);
    endtask

    task automatic t_capture();
        wr(A_MODE, 16'h0000);
        cap_event(1'b1, 0, "R7 code00 rise");
        cap_event(1'b0, 0, "R7 code00 fall");
        wr(A_MODE, 16'h0100);
        cap_event(1'b1, 1, "R7 code01 rise");
        cap_event(1'b0, 0, "R7 code01 fall");
        wr(A_MODE, 16'h0200);
        cap_event(1'b1, 0, "R7 code10 rise");
        cap_event(1'b0, 1, "R7 code10 fall");
        wr(A_MODE, 16'h0300);
        cap_event(1'b1, 1, "R7 code11 rise");
        cap_event(1'b0, 1, "R7 code11 fall");
    endtask

    task automatic t_compare_irq();
        logic [15:0] c, f;
        wr(A_MODE, 16'h0002);
        wr(A_FLAG, 16'h008F);
        rd(A_CNT, c);
        wr(A_CH0 + 4'd1, c + 16'd30);
        wait_cyc(10);
        rd(A_FLAG, f); chk("R8 no early match", 32'(f[1]), 0);
        wait_cyc(30);
        rd(A_FLAG, f); chk("R8 match flag", 32'(f[1]), 1);
        chk("R10 irq masked", 32'(irq), 0);
        wr(A_IE, 16'h0002);
        chk("R10 irq enabled", 32'(irq), 1);
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, f); chk("R9 other flag kept", 32'(f[1]), 1);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, f); chk("R9 flag cleared", 32'(f[1]), 0);
        chk("R10 irq dropped", 32'(irq), 0);
        wr(A_IE, 16'h0000);
    endtask

    task automatic t_no_ovf_ffff();
        logic [15:0] c, f;
        poll_count(16'hFFFF);
        @(negedge clk);
        rd(A_CNT, c);  chk("R6 reload to zero", 32'(c), 0);
        rd(A_FLAG, f); chk("R6 no overflow flag", 32'(f[7]), 0);
    endtask

    task automatic t_overflow();
        logic [15:0] c, f;
        wr(A_CTRL, 16'h0000);
        poll_count(16'hFFFF);
        @(negedge clk);
        rd(A_CNT, c);  chk("R2 wrap to zero", 32'(c), 0);
        rd(A_FLAG, f); chk("R2 overflow flag", 32'(f[7]), 1);
        chk("R10 ovf irq masked", 32'(irq), 0);
        wr(A_CTRL, 16'h0080);
        chk("R10 ovf irq", 32'(irq), 1);
        wr(A_FLAG, 16'h0080);
        rd(A_FLAG, f); chk("R9 ovf cleared", 32'(f[7]), 0);
        chk("R10 irq after clear", 32'(irq), 0);
    endtask

    task automatic ratio_window(input logic [15:0] ps, input int exp_steps);
        logic [15:0] c0, c1;
        wr(A_CTRL, ps);
        wait_cyc(300);
        rd(A_CNT, c0);
        wait_cyc(256);
        rd(A_CNT, c1);
        chk($sformatf("R2 ratio PR=%0d", ps), 32'(c1 - c0), 32'(exp_steps));
    endtask

    task automatic t_prescale();
        ratio_window(16'd2, 64);
        ratio_window(16'd0, 256);
        ratio_window(16'd7, 2);
    endtask

    task automatic t_holdoff();
        logic [15:0] c0, c, c1;
        bit moved;
        rd(A_CNT, c0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rd(A_CNT, c);
            if (c != c0) break;
        end
        wr(A_CTRL, 16'd0);
        rd(A_CNT, c0);
        moved = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(A_CNT, c);
            if (c != c0) moved = 1;
        end
        chk("R3 old ratio held", 32'(moved), 0);
        wait_cyc(150);
        rd(A_CNT, c0);
        wait_cyc(10);
        rd(A_CNT, c1);
        chk("R3 new ratio active", 32'(c1 - c0), 10);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_modulus();
        t_hold_zero();
        wr(A_CH0 + 4'd3, 16'hFFFF);
        t_capture();
        t_compare_irq();
        t_no_ovf_ffff();
        t_overflow();
        t_prescale();
        t_holdoff();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule